// File: doc/BRIEF.md
# Literal-Building Dual-Stack Execute Core

This block is the decode and execute core of a small dual-stack processor. It takes one 9-bit instruction per clock through a port with a valid strobe. Every accepted instruction completes in the clock edge that samples it. The core keeps two 16-bit stacks: a return stack and a data stack. For checking, it exposes the top value of each stack, the number of entries in each, a literal-run flag and four sticky error flags.

Wide constants are built from short instructions. The instruction's top bit marks it as a literal, and the low eight bits are its payload. The first literal in a run pushes its payload onto the return stack and starts the run. Each literal after it in the same run shifts the entry on top of the return stack left by eight bits and places its payload in the freed low byte. Any other accepted instruction ends the run. A dedicated instruction moves the finished constant from the return stack to the data stack. A handful of data-stack operations (duplicate, drop, add, swap) act on the value after that.

Top module: `lit_stack_core`

## Requirements
- R1: An accepted word with bit 8 = 1 is a literal carrying payload bits 7:0. When the run flag is clear and the return stack is not full, the literal pushes the payload, zero-extended to 16 bits, onto the return stack and sets the run flag.
- R2: An accepted literal while the run flag is set pushes nothing. The return-stack top becomes (old top << 8) | payload, and the return-stack depth is unchanged.
- R3: Any accepted word with bit 8 = 0 clears the run flag.
- R4: Two back-to-back literals leave one full 16-bit constant on the return stack. A third or later literal in the run keeps shifting and drops the bits that pass beyond bit 15.
- R5: A non-literal with bits 2:0 = 1 pops the return-stack top and pushes it onto the data stack in the same cycle.
- R6: For non-literals, the value of bits 2:0 selects the operation. 2 duplicates the data top. 3 drops the data top. 4 pops two entries and pushes their sum modulo 2^16. 5 exchanges the two top entries. 0, 6 and 7 change no stack.
- R7: A push onto a stack that already holds 8 entries sets that stack's sticky overflow flag and changes no stack. A first literal that hits a full return stack also leaves the run flag clear.
- R8: An operation that needs more entries than a stack holds sets that stack's sticky underflow flag and changes no stack. A move with an empty return stack, or with a full data stack, changes neither stack.
- R9: A cycle with the valid strobe low changes nothing, and a literal run continues across such cycles.
- R10: A synchronous reset empties both stacks and clears the run flag and all error flags. An empty stack shows a top value of 0.
- R11: Instructions can be issued on every cycle. Each instruction's result is visible after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction strobe |
| in_word | input | 9 | Instruction word |
| rs_top | output | 16 | Return-stack top (0 when empty) |
| ds_top | output | 16 | Data-stack top (0 when empty) |
| rs_depth | output | 4 | Return-stack entry count |
| ds_depth | output | 4 | Data-stack entry count |
| lit_active | output | 1 | Literal-run flag |
| rs_ovf | output | 1 | Sticky return-stack overflow |
| rs_unf | output | 1 | Sticky return-stack underflow |
| ds_ovf | output | 1 | Sticky data-stack overflow |
| ds_unf | output | 1 | Sticky data-stack underflow |

## Verification
The bench targets five cases.

- **Runs of three literals.** A core that kept high bits would show a value wider than the last two payloads.
- **A literal run broken only by idle cycles.** A core that cleared the flag on an idle cycle would push a new entry instead of shifting.
- **An add whose sum wraps past 16 bits.** This checks that the sum is taken modulo 2^16.
- **A literal into a full return stack, and the literal right after it.** A core that set the flag anyway would then corrupt the old top by shifting into it.
- **Moves with an empty source stack or a full destination stack.** A core that was not all-or-nothing would lose or duplicate a value between the stacks.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    localparam int unsigned INSN_W    = 9;
    localparam int unsigned PAY_W     = 8;
    localparam int unsigned WORD_W    = 16;
    localparam int unsigned STK_DEPTH = 8;
    localparam int unsigned SEL_W     = 3;

    // operation select codes carried in the low bits of a non-literal
    localparam logic [SEL_W-1:0] SEL_NOP  = 3'd0;
    localparam logic [SEL_W-1:0] SEL_R2D  = 3'd1;
    localparam logic [SEL_W-1:0] SEL_DUP  = 3'd2;
    localparam logic [SEL_W-1:0] SEL_DROP = 3'd3;
    localparam logic [SEL_W-1:0] SEL_ADD  = 3'd4;
    localparam logic [SEL_W-1:0] SEL_SWAP = 3'd5;

    typedef enum logic [2:0] {
        OP_NOP,
        OP_LIT,
        OP_R2D,
        OP_DUP,
        OP_DROP,
        OP_ADD,
        OP_SWAP
    } op_e;

    typedef enum logic [2:0] {
        ST_HOLD,
        ST_PUSH,
        ST_POP,
        ST_POP_WR,
        ST_WR_TOP,
        ST_SWAP
    } stk_cmd_e;

endpackage

// File: rtl/lsc_decode.sv
module lsc_decode
    import lsc_pkg::*;
#(
    parameter int unsigned IW = INSN_W,
    parameter int unsigned PW = PAY_W
) (
    input  logic [IW-1:0] insn,
    output op_e           op,
    output logic [PW-1:0] payload
);

    localparam int unsigned MARK_BIT = IW - 1;

    logic [SEL_W-1:0] sel;

    assign sel     = insn[SEL_W-1:0];
    assign payload = insn[PW-1:0];

    always_comb begin
        op = OP_NOP;
        if (insn[MARK_BIT]) begin
            op = OP_LIT;
        end else begin
            unique case (sel)
                SEL_R2D:  op = OP_R2D;
                SEL_DUP:  op = OP_DUP;
                SEL_DROP: op = OP_DROP;
                SEL_ADD:  op = OP_ADD;
                SEL_SWAP: op = OP_SWAP;
                default:  op = OP_NOP;
            endcase
        end
    end

endmodule

// File: rtl/lsc_stack.sv
module lsc_stack
    import lsc_pkg::*;
#(
    parameter int unsigned WIDTH = WORD_W,
    parameter int unsigned DEPTH = STK_DEPTH
) (
    input  logic                       clk,
    input  logic                       rst,
    input  stk_cmd_e                   cmd,
    input  logic [WIDTH-1:0]           wdata,
    output logic [WIDTH-1:0]           top,
    output logic [WIDTH-1:0]           second,
    output logic [$clog2(DEPTH+1)-1:0] depth,
    output logic                       full,
    output logic                       empty
);

    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [CW-1:0] ONE      = CW'(1);
    localparam logic [CW-1:0] TWO      = CW'(2);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [CW-1:0]               cnt;
    } stk_t;

    stk_t st_d, st_q;

    logic [CW-1:0] dm1, dm2;
    logic [AW-1:0] a_top, a_sec, a_new;
    logic          two_plus;

    assign dm1      = st_q.cnt - ONE;
    assign dm2      = st_q.cnt - TWO;
    assign a_top    = dm1[AW-1:0];
    assign a_sec    = dm2[AW-1:0];
    assign a_new    = st_q.cnt[AW-1:0];
    assign empty    = (st_q.cnt == '0);
    assign full     = (st_q.cnt == FULL_CNT);
    assign two_plus = (st_q.cnt >= TWO);
    assign top      = empty    ? '0 : st_q.mem[a_top];
    assign second   = two_plus ? st_q.mem[a_sec] : '0;
    assign depth    = st_q.cnt;

    always_comb begin
        st_d = st_q;
        unique case (cmd)
            ST_PUSH: begin
                if (!full) begin
                    st_d.mem[a_new] = wdata;
                    st_d.cnt        = st_q.cnt + ONE;
                end
            end
            ST_POP: begin
                if (!empty) begin
                    st_d.cnt = dm1;
                end
            end
            ST_POP_WR: begin
                if (two_plus) begin
                    st_d.mem[a_sec] = wdata;
                    st_d.cnt        = dm1;
                end
            end
            ST_WR_TOP: begin
                if (!empty) begin
                    st_d.mem[a_top] = wdata;
                end
            end
            ST_SWAP: begin
                if (two_plus) begin
                    st_d.mem[a_top] = st_q.mem[a_sec];
                    st_d.mem[a_sec] = st_q.mem[a_top];
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/lit_stack_core.sv
module lit_stack_core
    import lsc_pkg::*;
#(
    parameter int unsigned IW    = INSN_W,
    parameter int unsigned PW    = PAY_W,
    parameter int unsigned WW    = WORD_W,
    parameter int unsigned DEPTH = STK_DEPTH
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [IW-1:0]              in_word,
    output logic [WW-1:0]              rs_top,
    output logic [WW-1:0]              ds_top,
    output logic [$clog2(DEPTH+1)-1:0] rs_depth,
    output logic [$clog2(DEPTH+1)-1:0] ds_depth,
    output logic                       lit_active,
    output logic                       rs_ovf,
    output logic                       rs_unf,
    output logic                       ds_ovf,
    output logic                       ds_unf
);

    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam int unsigned KEEP_W = WW - PW;

    typedef struct packed {
        logic run;
        logic r_ovf;
        logic r_unf;
        logic d_ovf;
        logic d_unf;
    } core_t;

    core_t core_d, core_q;

    op_e           op;
    logic [PW-1:0] payload;

    stk_cmd_e      rs_cmd, ds_cmd;
    logic [WW-1:0] rs_wdata, ds_wdata;
    logic [WW-1:0] rs_tp, rs_sec, ds_tp, ds_sec;
    logic [CW-1:0] rs_cnt, ds_cnt;
    logic          rs_full, rs_empty, ds_full, ds_empty;

    logic [WW-1:0] lit_fresh, lit_shift, ds_sum;

    lsc_decode #(.IW(IW), .PW(PW)) u_dec (
        .insn    (in_word),
        .op      (op),
        .payload (payload)
    );

    lsc_stack #(.WIDTH(WW), .DEPTH(DEPTH)) u_rstk (
        .clk    (clk),
        .rst    (rst),
        .cmd    (rs_cmd),
        .wdata  (rs_wdata),
        .top    (rs_tp),
        .second (rs_sec),
        .depth  (rs_cnt),
        .full   (rs_full),
        .empty  (rs_empty)
    );

    lsc_stack #(.WIDTH(WW), .DEPTH(DEPTH)) u_dstk (
        .clk    (clk),
        .rst    (rst),
        .cmd    (ds_cmd),
        .wdata  (ds_wdata),
        .top    (ds_tp),
        .second (ds_sec),
        .depth  (ds_cnt),
        .full   (ds_full),
        .empty  (ds_empty)
    );

    // candidate values, computed alongside decode
    assign lit_fresh = {{KEEP_W{1'b0}}, payload};
    assign lit_shift = {rs_tp[KEEP_W-1:0], payload};
    assign ds_sum    = ds_tp + ds_sec;

    always_comb begin
        core_d   = core_q;
        rs_cmd   = ST_HOLD;
        ds_cmd   = ST_HOLD;
        rs_wdata = '0;
        ds_wdata = '0;
        if (in_valid) begin
            core_d.run = 1'b0;
            unique case (op)
                OP_LIT: begin
                    if (core_q.run) begin
                        rs_cmd     = ST_WR_TOP;
                        rs_wdata   = lit_shift;
                        core_d.run = 1'b1;
                    end else if (rs_full) begin
                        core_d.r_ovf = 1'b1;
                    end else begin
                        rs_cmd     = ST_PUSH;
                        rs_wdata   = lit_fresh;
                        core_d.run = 1'b1;
                    end
                end
                OP_R2D: begin
                    if (rs_empty) begin
                        core_d.r_unf = 1'b1;
                    end else if (ds_full) begin
                        core_d.d_ovf = 1'b1;
                    end else begin
                        rs_cmd   = ST_POP;
                        ds_cmd   = ST_PUSH;
                        ds_wdata = rs_tp;
                    end
                end
                OP_DUP: begin
                    if (ds_empty) begin
                        core_d.d_unf = 1'b1;
                    end else if (ds_full) begin
                        core_d.d_ovf = 1'b1;
                    end else begin
                        ds_cmd   = ST_PUSH;
                        ds_wdata = ds_tp;
                    end
                end
                OP_DROP: begin
                    if (ds_empty) begin
                        core_d.d_unf = 1'b1;
                    end else begin
                        ds_cmd = ST_POP;
                    end
                end
                OP_ADD: begin
                    if (ds_cnt < CW'(2)) begin
                        core_d.d_unf = 1'b1;
                    end else begin
                        ds_cmd   = ST_POP_WR;
                        ds_wdata = ds_sum;
                    end
                end
                OP_SWAP: begin
                    if (ds_cnt < CW'(2)) begin
                        core_d.d_unf = 1'b1;
                    end else begin
                        ds_cmd = ST_SWAP;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign rs_top     = rs_tp;
    assign ds_top     = ds_tp;
    assign rs_depth   = rs_cnt;
    assign ds_depth   = ds_cnt;
    assign lit_active = core_q.run;
    assign rs_ovf     = core_q.r_ovf;
    assign rs_unf     = core_q.r_unf;
    assign ds_ovf     = core_q.d_ovf;
    assign ds_unf     = core_q.d_unf;

endmodule

// File: rtl/lsc_check.sv
module lsc_check #(
    parameter int unsigned IW    = 9,
    parameter int unsigned PW    = 8,
    parameter int unsigned WW    = 16,
    parameter int unsigned DEPTH = 8
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       in_valid,
    input logic [IW-1:0]              in_word,
    input logic [WW-1:0]              rs_top,
    input logic [WW-1:0]              ds_top,
    input logic [$clog2(DEPTH+1)-1:0] rs_depth,
    input logic [$clog2(DEPTH+1)-1:0] ds_depth,
    input logic                       lit_active,
    input logic                       rs_ovf,
    input logic                       rs_unf,
    input logic                       ds_ovf,
    input logic                       ds_unf
);

    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [CW-1:0] ONE      = CW'(1);

    logic is_lit, is_dup, is_drop;
    assign is_lit  = in_valid && in_word[IW-1];
    assign is_dup  = in_valid && !in_word[IW-1] && (in_word[2:0] == 3'd2);
    assign is_drop = in_valid && !in_word[IW-1] && (in_word[2:0] == 3'd3);

    assert_lit_push_R1: assert property (@(posedge clk) disable iff (rst)
        (is_lit && !lit_active && rs_depth != FULL_CNT) |=>
            (rs_depth == $past(rs_depth) + ONE) && lit_active &&
            (rs_top == {{(WW-PW){1'b0}}, $past(in_word[PW-1:0])}));

    assert_lit_shift_R2: assert property (@(posedge clk) disable iff (rst)
        (is_lit && lit_active) |=>
            (rs_depth == $past(rs_depth)) && lit_active &&
            (rs_top == {$past(rs_top[WW-PW-1:0]), $past(in_word[PW-1:0])}));

    assert_run_ends_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_word[IW-1]) |=> !lit_active);

    assert_full_lit_R7: assert property (@(posedge clk) disable iff (rst)
        (is_lit && !lit_active && rs_depth == FULL_CNT) |=>
            rs_ovf && !lit_active && $stable(rs_top) && $stable(rs_depth));

    assert_dup_full_R7: assert property (@(posedge clk) disable iff (rst)
        (is_dup && ds_depth == FULL_CNT) |=> ds_ovf && $stable(ds_depth));

    assert_sticky_ovf_R7: assert property (@(posedge clk) disable iff (rst)
        (rs_ovf || ds_ovf) |=> (rs_ovf || !$past(rs_ovf)) && (ds_ovf || !$past(ds_ovf)));

    assert_drop_empty_R8: assert property (@(posedge clk) disable iff (rst)
        (is_drop && ds_depth == '0) |=> ds_unf && (ds_depth == '0));

    assert_sticky_unf_R8: assert property (@(posedge clk) disable iff (rst)
        (rs_unf || ds_unf) |=> (rs_unf || !$past(rs_unf)) && (ds_unf || !$past(ds_unf)));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(rs_top) && $stable(ds_top) && $stable(rs_depth) &&
                      $stable(ds_depth) && $stable(lit_active));

    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (rs_depth == '0) && (ds_depth == '0) && !lit_active &&
                !rs_ovf && !rs_unf && !ds_ovf && !ds_unf);

    assert_depth_bound_R11: assert property (@(posedge clk) disable iff (rst)
        (rs_depth <= FULL_CNT) && (ds_depth <= FULL_CNT));

endmodule

bind lit_stack_core lsc_check #(
    .IW(IW), .PW(PW), .WW(WW), .DEPTH(DEPTH)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_word    (in_word),
    .rs_top     (rs_top),
    .ds_top     (ds_top),
    .rs_depth   (rs_depth),
    .ds_depth   (ds_depth),
    .lit_active (lit_active),
    .rs_ovf     (rs_ovf),
    .rs_unf     (rs_unf),
    .ds_ovf     (ds_ovf),
    .ds_unf     (ds_unf)
);

// File: tb/sim_lit_stack_core.sv
module sim_lit_stack_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [8:0]  in_word = '0;
    logic [15:0] rs_top, ds_top;
    logic [3:0]  rs_depth, ds_depth;
    logic        lit_active, rs_ovf, rs_unf, ds_ovf, ds_unf;

    lit_stack_core u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .rs_top(rs_top), .ds_top(ds_top), .rs_depth(rs_depth), .ds_depth(ds_depth),
        .lit_active(lit_active), .rs_ovf(rs_ovf), .rs_unf(rs_unf),
        .ds_ovf(ds_ovf), .ds_unf(ds_unf)
    );

    always #2 clk = ~clk;   // 4 ns period

    typedef struct packed {
        logic [15:0] rtop;
        logic [15:0] dtop;
        logic [3:0]  rdep;
        logic [3:0]  ddep;
        logic        run;
        logic        ro, ru, dov, du;
    } snap_t;

    snap_t exp_q[$];
    string tag_q[$];
    int    stamp_q[$];

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit done = 0;

    // reference model state
    logic [15:0] rs_m[$];
    logic [15:0] ds_m[$];
    logic        run_m = 0, ro_m = 0, ru_m = 0, do_m = 0, du_m = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic snap_t model_snap();
        snap_t s;
        s.rtop = (rs_m.size() > 0) ? rs_m[$] : 16'h0;
        s.dtop = (ds_m.size() > 0) ? ds_m[$] : 16'h0;
        s.rdep = 4'(rs_m.size());
        s.ddep = 4'(ds_m.size());
        s.run  = run_m;
        s.ro = ro_m; s.ru = ru_m; s.dov = do_m; s.du = du_m;
        return s;
    endfunction

    // monitor: compare each expected item once its edge has passed
    always @(negedge clk) begin
        while (stamp_q.size() > 0 && cyc > stamp_q[0]) begin
            snap_t act, exp;
            string tg;
            act = {rs_top, ds_top, rs_depth, ds_depth, lit_active,
                   rs_ovf, rs_unf, ds_ovf, ds_unf};
            exp = exp_q.pop_front();
            tg  = tag_q.pop_front();
            void'(stamp_q.pop_front());
            checks++;
            if (act !== exp) begin
                fails++;
                $display("FAIL %s: actual rs=%h ds=%h rd=%0d dd=%0d run=%b err=%b%b%b%b expected rs=%h ds=%h rd=%0d dd=%0d run=%b err=%b%b%b%b",
                    tg, act.rtop, act.dtop, act.rdep, act.ddep, act.run,
                    act.ro, act.ru, act.dov, act.du,
                    exp.rtop, exp.dtop, exp.rdep, exp.ddep, exp.run,
                    exp.ro, exp.ru, exp.dov, exp.du);
            end
        end
    end

    task automatic model_apply(input logic [8:0] w);
        if (w[8]) begin
            if (run_m) begin
                logic [15:0] t;
                t = rs_m.pop_back();
                rs_m.push_back({t[7:0], w[7:0]});
            end else if (rs_m.size() == 8) begin
                ro_m = 1;
            end else begin
                rs_m.push_back({8'h00, w[7:0]});
                run_m = 1;
            end
        end else begin
            run_m = 0;
            case (w[2:0])
                3'd1: begin
                    if (rs_m.size() == 0) ru_m = 1;
                    else if (ds_m.size() == 8) do_m = 1;
                    else ds_m.push_back(rs_m.pop_back());
                end
                3'd2: begin
                    if (ds_m.size() == 0) du_m = 1;
                    else if (ds_m.size() == 8) do_m = 1;
                    else ds_m.push_back(ds_m[$]);
                end
                3'd3: begin
                    if (ds_m.size() == 0) du_m = 1;
                    else void'(ds_m.pop_back());
                end
                3'd4: begin
                    if (ds_m.size() < 2) du_m = 1;
                    else begin
                        logic [15:0] a, b;
                        a = ds_m.pop_back();
                        b = ds_m.pop_back();
                        ds_m.push_back(a + b);
                    end
                end
                3'd5: begin
                    if (ds_m.size() < 2) du_m = 1;
                    else begin
                        logic [15:0] a, b;
                        a = ds_m.pop_back();
                        b = ds_m.pop_back();
                        ds_m.push_back(a);
                        ds_m.push_back(b);
                    end
                end
                default: ;
            endcase
        end
    endtask

    // driver: called just after a rising edge, occupies exactly one cycle
    task automatic step(input logic v, input logic [8:0] w, input string tg);
        in_valid = v;
        in_word  = w;
        if (v) model_apply(w);
        exp_q.push_back(model_snap());
        tag_q.push_back(tg);
        stamp_q.push_back(cyc);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic do_reset(input string tg);
        rst = 1'b1;
        in_valid = 1'b1;
        in_word = 9'h1AA;
        rs_m.delete(); ds_m.delete();
        run_m = 0; ro_m = 0; ru_m = 0; do_m = 0; du_m = 0;
        exp_q.push_back(model_snap());
        tag_q.push_back(tg);
        stamp_q.push_back(cyc);
        @(posedge clk);
        #1;
        rst = 1'b0;
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        @(posedge clk); #1;
        do_reset("R10 reset state");
        step(0, 9'h1FF, "R9 idle after reset");
        step(1, 9'h1A3, "R1 first literal");
        step(1, 9'h15C, "R2 R4 second literal");
        step(1, 9'h1FF, "R4 third literal drops high byte");
        step(1, 9'h000, "R3 nop ends run");
        step(1, 9'h112, "R1 new run pushes");
        step(0, 9'h003, "R9 idle keeps run");
        step(0, 9'h0FF, "R9 idle again");
        step(1, 9'h134, "R9 R2 run continues across idle");
        step(1, 9'h001, "R5 move to data");
        step(1, 9'h001, "R5 second move");
        step(1, 9'h004, "R6 add");
        step(1, 9'h1FF, "R11 back-to-back literal");
        step(1, 9'h1FF, "R4 constant FFFF");
        step(1, 9'h001, "R5 move FFFF");
        step(1, 9'h100, "R1 literal 00");
        step(1, 9'h101, "R2 literal 01");
        step(1, 9'h001, "R5 move 0001");
        step(1, 9'h004, "R6 add wraps");
        step(1, 9'h005, "R6 swap");
        step(1, 9'h002, "R6 dup");
        step(1, 9'h003, "R6 drop");
        step(1, 9'h1C0, "R1 literal before other ops");
        step(1, 9'h006, "R6 code 6 no stack change");
        step(1, 9'h007, "R6 code 7 no stack change");
        step(1, 9'h0F8, "R6 code 0 with high bits");
        for (int i = 0; i < 4; i++) step(1, 9'h003, "R6 R8 drain data");
        step(1, 9'h004, "R8 add on short stack");
        step(1, 9'h005, "R8 swap on short stack");
        step(1, 9'h002, "R8 dup on empty");
        for (int i = 0; i < 4; i++) step(1, 9'h001, "R5 R8 drain return");
        step(1, 9'h001, "R8 move from empty return");
        do_reset("R10 mid-run reset");
        for (int i = 0; i < 8; i++) begin
            step(1, 9'(9'h110 + i), "R1 fill return");
            step(1, 9'h000, "R3 separate");
        end
        step(1, 9'h177, "R7 literal into full return");
        step(1, 9'h188, "R7 next literal does not shift");
        step(1, 9'h001, "R5 move one");
        for (int i = 0; i < 7; i++) step(1, 9'h002, "R6 dup fill data");
        step(1, 9'h002, "R7 dup into full data");
        step(1, 9'h001, "R8 move onto full data");
        step(1, 9'h104, "R1 push after overflow");
        do_reset("R10 final reset");
        step(0, 9'h000, "R9 idle after final reset");
        repeat (3) @(posedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule